// File: doc/BRIEF.md
# Printer Port Register Block with Built-in Responder

This block gives a host a byte-wide view of a standard printer port: a data register, a status register and a control register behind a small synchronous bus with a 3-bit address, separate write and read strobes, and one interrupt line. A printer responder sits inside the block. It produces the busy and acknowledge handshake purely from register traffic, so a host driver that polls or waits on interrupts sees a plausible printer without any cable timing.

A rising edge of the strobe control bit hands the byte held in the output-data register to a downstream byte sink through a one-clock valid pulse. Every status read can step the acknowledge/busy sequence forward. A separate load strobe fills an input-data register from an 8-bit external input. When the direction control bit is set, data reads return that input register.

Top module: `pp_port_regs`

## Requirements
- R1: Offsets 0, 1 and 2 map to data, status and control. A read at any offset from 3 to 7 returns 0xFF. Read data is registered and appears on `bus_rdata` in the cycle after `bus_rd`, then holds until the next read. A read is ignored in any cycle where `bus_wr` is also high.
- R2: Each control write stores the written byte with bits 7 and 6 forced to 1, and a control read returns the stored byte.
- R3: A control write with bit 2 (init) at 0 loads status with 0xD8: bit 7 busy-complement, bit 6 ack, bit 4 online and bit 3 error-complement are set, and every other bit is cleared.
- R4: A control write with init at 1, bit 3 (select) at 1 and bit 0 (strobe) at 1 clears status bit 7. If the stored strobe bit was 0 before that write, `sink_valid` is high for exactly the next cycle, and `sink_byte` then carries the output-data register as it was at the write.
- R5: A control write with init at 1, select at 1 and strobe at 0 sets interrupt-pending, but only if bit 4 (interrupt enable) of the control value stored before the write is 1. `irq` is the registered pending flag and rises in the cycle after that write.
- R6: A status read returns status as it was before the read and clears interrupt-pending. If status bit 7 and stored control strobe are both 0, the same read then steps the handshake: a set bit 6 is cleared; otherwise bits 6 and 7 are both set.
- R7: A data read returns the input-data register when control bit 5 (direction) is 1, and the last byte written to offset 0 when it is 0.
- R8: Synchronous reset sets both data registers to 0xFF, status to 0xD9, control to 0xCC and `bus_rdata` to 0xFF, and clears interrupt-pending and `sink_valid`.
- R9: The input-data register loads `pin_data` in every cycle where `pin_load` is high. A data read in that same cycle returns the old value.
- R10: Writes to offset 1 or to offsets 3 to 7 change no register. A control write with init at 1 and select at 0 leaves status and interrupt-pending unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt-pending flag |
| pin_data | input | DATA_W | External byte for the input-data register |
| pin_load | input | 1 | Load strobe for the input-data register |
| sink_valid | output | 1 | One-clock pulse: a byte goes to the sink |
| sink_byte | output | DATA_W | Byte handed to the sink |

## Verification
The bench builds the block with its default widths: an 8-bit data path and a 3-bit offset. At these widths every offset, including all five unmapped ones, and every control bit pattern can be reached. A directed sequence walks the handshake through strobe edges, interrupt arming, the two-step acknowledge toggle, init, the direction switch and a mid-run reset. A long random phase then mixes every access type with input loads, and a behavioural model is compared against the outputs on every clock.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // control bit positions
  localparam int CB_STROBE = 0;
  localparam int CB_INIT   = 2;
  localparam int CB_SEL    = 3;
  localparam int CB_IEN    = 4;
  localparam int CB_DIR    = 5;
  // status bit positions
  localparam int SB_ACK    = 6;
  localparam int SB_BUSYN  = 7;

  localparam int OFS_DATA = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_CTRL = 2;

  localparam logic [7:0] RST_DATA   = 8'hFF;
  localparam logic [7:0] RST_STAT   = 8'hD9;
  localparam logic [7:0] RST_CTRL   = 8'hCC;
  localparam logic [7:0] INIT_STAT  = 8'hD8;
  localparam logic [7:0] CTRL_FORCE = 8'hC0;
  localparam logic [7:0] IDLE_READ  = 8'hFF;

  typedef struct packed {
    logic wr_data;
    logic wr_ctrl;
    logic rd_data;
    logic rd_stat;
    logic rd_ctrl;
    logic rd_other;
  } acc_t;
endpackage

// File: rtl/pp_data_regs.sv
module pp_data_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pp_pkg::acc_t      acc,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              pin_load,
  output logic [DATA_W-1:0] dout_q,
  output logic [DATA_W-1:0] din_q
);
  import pp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= DATA_W'(RST_DATA);
      din_q  <= DATA_W'(RST_DATA);
    end else begin
      if (acc.wr_data) dout_q <= wdata;
      if (pin_load)    din_q  <= pin_data;
    end
  end
endmodule

// File: rtl/pp_ctrl_reg.sv
module pp_ctrl_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pp_pkg::acc_t      acc,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q
);
  import pp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)              ctrl_q <= DATA_W'(RST_CTRL);
    else if (acc.wr_ctrl) ctrl_q <= wdata | DATA_W'(CTRL_FORCE);
  end
endmodule

// File: rtl/pp_handshake.sv
module pp_handshake #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pp_pkg::acc_t      acc,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] dout_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              pend_q,
  output logic              sink_valid_q,
  output logic [DATA_W-1:0] sink_byte_q
);
  import pp_pkg::*;

  logic [DATA_W-1:0] nctl;
  logic              step_ok;

  assign nctl    = wdata | DATA_W'(CTRL_FORCE);
  assign step_ok = !stat_q[SB_BUSYN] && !ctrl_q[CB_STROBE];

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q       <= DATA_W'(RST_STAT);
      pend_q       <= 1'b0;
      sink_valid_q <= 1'b0;
      sink_byte_q  <= DATA_W'(RST_DATA);
    end else begin
      sink_valid_q <= 1'b0;
      if (acc.wr_ctrl) begin
        if (!nctl[CB_INIT]) begin
          stat_q <= DATA_W'(INIT_STAT);
        end else if (nctl[CB_SEL]) begin
          if (nctl[CB_STROBE]) begin
            stat_q[SB_BUSYN] <= 1'b0;
            if (!ctrl_q[CB_STROBE]) begin
              sink_valid_q <= 1'b1;
              sink_byte_q  <= dout_q;
            end
          end else if (ctrl_q[CB_IEN]) begin
            pend_q <= 1'b1;
          end
        end
      end else if (acc.rd_stat) begin
        pend_q <= 1'b0;
        if (step_ok) begin
          if (stat_q[SB_ACK]) begin
            stat_q[SB_ACK] <= 1'b0;
          end else begin
            stat_q[SB_ACK]   <= 1'b1;
            stat_q[SB_BUSYN] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pp_rd_mux.sv
module pp_rd_mux #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pp_pkg::acc_t      acc,
  input  logic [DATA_W-1:0] dout_q,
  input  logic [DATA_W-1:0] din_q,
  input  logic [DATA_W-1:0] stat_q,
  input  logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] rdata_q
);
  import pp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= DATA_W'(IDLE_READ);
    end else if (acc.rd_data) begin
      rdata_q <= ctrl_q[CB_DIR] ? din_q : dout_q;
    end else if (acc.rd_stat) begin
      rdata_q <= stat_q;
    end else if (acc.rd_ctrl) begin
      rdata_q <= ctrl_q;
    end else if (acc.rd_other) begin
      rdata_q <= DATA_W'(IDLE_READ);
    end
  end
endmodule

// File: rtl/pp_port_regs.sv
module pp_port_regs #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              pin_load,
  output logic              sink_valid,
  output logic [DATA_W-1:0] sink_byte
);
  import pp_pkg::*;

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  acc_t              acc;
  logic              rd_en;
  logic [DATA_W-1:0] dout_q, din_q, ctrl_q, stat_q;

  assign rd_en = bus_rd && !bus_wr;

  always_comb begin
    acc          = '0;
    acc.wr_data  = bus_wr && (bus_addr == A_DATA);
    acc.wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    acc.rd_data  = rd_en && (bus_addr == A_DATA);
    acc.rd_stat  = rd_en && (bus_addr == A_STAT);
    acc.rd_ctrl  = rd_en && (bus_addr == A_CTRL);
    acc.rd_other = rd_en && (bus_addr != A_DATA) && (bus_addr != A_STAT)
                   && (bus_addr != A_CTRL);
  end

  pp_data_regs #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata),
    .pin_data(pin_data), .pin_load(pin_load),
    .dout_q(dout_q), .din_q(din_q)
  );

  pp_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata), .ctrl_q(ctrl_q)
  );

  pp_handshake #(.DATA_W(DATA_W)) u_hs (
    .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .dout_q(dout_q), .stat_q(stat_q), .pend_q(irq),
    .sink_valid_q(sink_valid), .sink_byte_q(sink_byte)
  );

  pp_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .acc(acc), .dout_q(dout_q), .din_q(din_q),
    .stat_q(stat_q), .ctrl_q(ctrl_q), .rdata_q(bus_rdata)
  );
endmodule

// File: rtl/pp_port_regs_chk.sv
module pp_port_regs_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              sink_valid
);
  p_unmapped_ff_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr > ADDR_W'(2)) |=> (bus_rdata == DATA_W'(8'hFF)));

  p_ctrl_top_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(2)) |=> (bus_rdata[7:6] == 2'b11));

  p_sink_one_clock_r4: assert property (@(posedge clk) disable iff (rst)
    sink_valid |=> !sink_valid);

  p_sink_cause_r4: assert property (@(posedge clk) disable iff (rst)
    sink_valid |-> $past(bus_wr && bus_addr == ADDR_W'(2) && bus_wdata[0]
                         && bus_wdata[2] && bus_wdata[3]));

  p_irq_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(1)) |=> !irq);

  p_irq_needs_ctrl_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(bus_wr && bus_addr == ADDR_W'(2)));

  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && !sink_valid && bus_rdata == DATA_W'(8'hFF)));
endmodule

bind pp_port_regs pp_port_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sink_valid(sink_valid)
);

// File: tb/pp_port_regs_test.sv
`timescale 1ns/1ps
module pp_port_regs_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic [7:0] pin_data = '0;
  logic       pin_load = 1'b0;
  logic       sink_valid;
  logic [7:0] sink_byte;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit started = 0;

  always #5 clk = ~clk;

  pp_port_regs #(.DATA_W(8), .ADDR_W(3)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .pin_data(pin_data), .pin_load(pin_load),
    .sink_valid(sink_valid), .sink_byte(sink_byte)
  );

  // behavioural reference model
  int m_dw, m_dr, m_st, m_ct, m_pend, m_rd, m_sv, m_sb;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_dw = 255; m_dr = 255; m_st = 'hD9; m_ct = 'hCC;
      m_pend = 0; m_rd = 255; m_sv = 0; m_sb = 255;
    end else begin
      m_sv = 0;
      if (bus_wr) begin
        if (bus_addr == 0) m_dw = bus_wdata;
        else if (bus_addr == 2) begin
          int v;
          v = bus_wdata | 'hC0;
          if ((v & 4) == 0) m_st = 'hD8;
          else if ((v & 8) != 0) begin
            if ((v & 1) != 0) begin
              m_st = m_st & 'h7F;
              if ((m_ct & 1) == 0) begin m_sv = 1; m_sb = m_dw; end
            end else if ((m_ct & 16) != 0) m_pend = 1;
          end
          m_ct = v;
        end
      end else if (bus_rd) begin
        case (bus_addr)
          0: m_rd = ((m_ct & 32) != 0) ? m_dr : m_dw;
          1: begin
            m_rd = m_st;
            m_pend = 0;
            if ((m_st & 128) == 0 && (m_ct & 1) == 0) begin
              if ((m_st & 64) != 0) m_st = m_st & ~64 & 255;
              else m_st = m_st | 192;
            end
          end
          2: m_rd = m_ct;
          default: m_rd = 255;
        endcase
      end
      if (pin_load) m_dr = pin_data;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (started) begin
      chk("R1 rdata vs model", bus_rdata, m_rd);
      chk("R5 irq vs model", irq, m_pend);
      chk("R4 sink_valid vs model", sink_valid, m_sv);
      if (m_sv) chk("R4 sink_byte vs model", sink_byte, m_sb);
    end
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R8 irq after reset", irq, 0);
    chk("R8 sink_valid after reset", sink_valid, 0);
    chk("R8 rdata after reset", bus_rdata, 'hFF);
    rd(2, v); chk("R8 control reset", v, 'hCC);
    rd(1, v); chk("R8 status reset", v, 'hD9);
    rd(0, v); chk("R8 data reset", v, 'hFF);

    wr(0, 8'h5A);
    rd(0, v); chk("R7 data out readback", v, 'h5A);
    rd(5, v); chk("R1 unmapped read", v, 'hFF);
    wr(1, 8'h00); wr(6, 8'h00);
    rd(1, v); chk("R10 status write ignored", v, 'hD9);
    rd(0, v); chk("R10 offset 6 write ignored", v, 'h5A);

    wr(2, 8'h1C); chk("R5 no irq without prior enable", irq, 0);
    wr(2, 8'h1C); chk("R5 irq armed", irq, 1);
    rd(2, v); chk("R2 control stored", v, 'hDC);

    wr(2, 8'h1D);
    chk("R4 sink pulse", sink_valid, 1);
    chk("R4 sink byte", sink_byte, 'h5A);
    @(negedge clk); chk("R4 pulse one clock", sink_valid, 0);
    wr(2, 8'h1D); chk("R4 no resend at steady strobe", sink_valid, 0);

    rd(1, v); chk("R6 status busy cleared", v, 'h59);
    chk("R6 irq cleared by status read", irq, 0);
    rd(1, v); chk("R6 no step with strobe high", v, 'h59);

    wr(2, 8'h1C); chk("R5 irq rearmed", irq, 1);
    rd(1, v); chk("R6 read before ack clear", v, 'h59);
    rd(1, v); chk("R6 ack cleared", v, 'h19);
    rd(1, v); chk("R6 ack and busy set", v, 'hD9);
    rd(1, v); chk("R6 stable when busy", v, 'hD9);

    wr(2, 8'h18);
    rd(1, v); chk("R3 init status", v, 'hD8);
    wr(2, 8'h00);
    rd(2, v); chk("R2 forced top bits", v, 'hC0);

    @(negedge clk); pin_data = 8'hA5; pin_load = 1'b1;
    @(negedge clk); pin_load = 1'b0;
    wr(2, 8'h2C);
    rd(0, v); chk("R7 R9 input data read", v, 'hA5);
    rd(2, v); chk("R2 direction stored", v, 'hEC);
    @(negedge clk); bus_addr = 0; bus_rd = 1'b1; pin_data = 8'h3C; pin_load = 1'b1;
    @(negedge clk); bus_rd = 1'b0; pin_load = 1'b0;
    chk("R9 load same cycle returns old", bus_rdata, 'hA5);
    rd(0, v); chk("R9 new input value", v, 'h3C);

    wr(2, 8'h04);
    rd(1, v); chk("R10 select low leaves status", v, 'hD8);

    @(negedge clk); bus_addr = 2; bus_wdata = 8'h0C; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R1 read ignored during write", bus_rdata, 'hD8);

    wr(0, 8'h77);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(0, v); chk("R8 data after mid reset", v, 'hFF);
    rd(1, v); chk("R8 status after mid reset", v, 'hD9);

    for (int i = 0; i < 3000; i++) begin
      int op;
      @(negedge clk);
      op = $urandom_range(0, 9);
      bus_addr = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) != 0) bus_addr = 3'($urandom_range(0, 2));
      bus_wdata = 8'($urandom);
      if (bus_addr == 2 && $urandom_range(0, 3) != 0) bus_wdata = bus_wdata | 8'h0C;
      bus_wr = (op < 4);
      bus_rd = (op >= 3 && op < 8);
      pin_load = ($urandom_range(0, 7) == 0);
      pin_data = 8'($urandom);
    end
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0; pin_load = 1'b0;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule